// File: doc/BRIEF.md
# Probabilistic Neighbour-Row Refresher

This block is a stateless row-hammer mitigator placed on the activate command stream of a DRAM controller. Each time an activate is presented, the block compares a pseudo-random number against a programmable probability and, if the number falls below it, asks for a refresh of one row that sits directly next to the row just opened. No per-row history is kept. Over any window the expected number of refresh requests is the probability times the number of activates, whichever rows are being opened.

The probability is a 16-bit unsigned fraction of 65536. This covers everything from roughly 0.001 (a value of 66) up to 0.2 (a value of 13107) and beyond. Randomness comes from a 16-bit maximal-length LFSR that steps once per activate and can be reseeded. Refresh requests leave through a single-entry valid/ready slot. When a new request fires while the slot is still blocked, the new request is discarded and counted.

Top module: `nbr_refresh_top`

## Requirements
- R1: While rst_ni is low, ref_valid_o is 0, drop_cnt_o is 0, and the LFSR holds 16'hACE1.
- R2: An activate fires a refresh exactly when the LFSR value before the activate is strictly below prob_i. A prob_i of 0 never fires, and a prob_i of 16'hFFFF fires for every LFSR value except 16'hFFFF.
- R3: The LFSR shifts left by one on each cycle with act_valid_i=1, taking in feedback = s[15]^s[13]^s[12]^s[10] at bit 0. It holds its value on every other cycle and is never zero.
- R4: seed_load_i=1 loads seed_i into the LFSR at the clock edge, or 16'hACE1 if seed_i is zero. A load takes priority over stepping, while an activate in the same cycle is still decided on the old value.
- R5: For a firing activate, a feedback bit of 1 selects row+1 and a feedback bit of 0 selects row-1. The feedback bit is the one computed from the pre-activate LFSR value.
- R6: Row 0 always yields row 1, and row ROWS-1 always yields row ROWS-2, whatever the feedback bit.
- R7: Once ref_valid_o=1 while ref_ready_i=0, ref_valid_o stays 1 and ref_row_o stays unchanged in the next cycle.
- R8: A firing activate that meets ref_valid_o=1 and ref_ready_i=0 leaves the slot unchanged and increments drop_cnt_o. The count saturates at its maximum.
- R9: A firing activate in a cycle where ref_ready_i=1 replaces the outgoing request with no drop. A cycle with ref_ready_i=1 and no fire clears ref_valid_o.
- R10: All outputs are registered, so a fire shows on ref_valid_o and ref_row_o one clock after the activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_valid_i | input | 1 | Activate command present |
| act_row_i | input | ROW_W | Row address of the activate |
| prob_i | input | 16 | Refresh probability as a fraction of 65536 |
| seed_load_i | input | 1 | Load seed_i into the LFSR |
| seed_i | input | 16 | LFSR seed value |
| ref_valid_o | output | 1 | Refresh request pending |
| ref_row_o | output | ROW_W | Victim row to refresh |
| ref_ready_i | input | 1 | Consumer accepts the request |
| drop_cnt_o | output | DROP_W | Saturating count of discarded requests |

## Verification
The bench builds the block with ROWS=16 and DROP_W=4. With 16 rows, random activates land on both bank-edge rows often enough to check the forced neighbour choice. With a 4-bit counter, a short stall with ready held low drives the drop count into saturation. Probabilities of 0, 66, 13107 and 16'hFFFF together cover never, rare, typical and almost-always firing. Seed loads with zero and with non-zero values, some of them coinciding with activates, check the priority of a load over a step.

// File: rtl/nbr_refresh_pkg.sv
package nbr_refresh_pkg;
  localparam int unsigned      LFSR_W        = 16;
  localparam logic [15:0]      LFSR_TAPS     = 16'hB400; // bits 15,13,12,10
  localparam logic [15:0]      SEED_FALLBACK = 16'hACE1;

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} nbr_dir_e;
endpackage

// File: rtl/nbr_lfsr.sv
module nbr_lfsr
  import nbr_refresh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [LFSR_W-1:0] state_o,
  output logic              fb_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] seed_safe;

  assign fb_o      = ^(state_q & LFSR_TAPS);
  assign seed_safe = (seed_i == '0) ? SEED_FALLBACK : seed_i;
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= SEED_FALLBACK;
    else if (load_i)  state_q <= seed_safe;
    else if (step_i)  state_q <= {state_q[LFSR_W-2:0], fb_o};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R3
  AST_LFSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(state_q)); // R3
  AST_LFSR_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> state_q[LFSR_W-1:1] == $past(state_q[LFSR_W-2:0])); // R3
  AST_SEED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && seed_i == '0) |=> state_q == SEED_FALLBACK); // R4
endmodule

// File: rtl/nbr_select.sv
module nbr_select
  import nbr_refresh_pkg::*;
#(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic [ROW_W-1:0] row_i,
  input  nbr_dir_e         dir_i,
  output logic [ROW_W-1:0] nbr_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  always_comb begin
    if (row_i == '0)              nbr_o = ROW_W'(1);
    else if (row_i >= LAST_ROW)   nbr_o = LAST_ROW - ROW_W'(1);
    else if (dir_i == DIR_UP)     nbr_o = row_i + ROW_W'(1);
    else                          nbr_o = row_i - ROW_W'(1);
  end
endmodule

// File: rtl/nbr_req_slot.sv
module nbr_req_slot #(
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic              valid_q;
  logic [ROW_W-1:0]  row_q;
  logic [DROP_W-1:0] drop_q;
  logic              blocked;

  assign blocked = valid_q && !ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      row_q   <= '0;
    end else if (fire_i && !blocked) begin
      valid_q <= 1'b1;
      row_q   <= row_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   drop_q <= '0;
    else if (fire_i && blocked && drop_q != DROP_MAX) drop_q <= drop_q + DROP_W'(1);
  end

  assign valid_o    = valid_q;
  assign row_o      = row_q;
  assign drop_cnt_o = drop_q;

  AST_HOLD_UNTIL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(row_q))); // R7
  AST_DROP_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> drop_q >= $past(drop_q)); // R8
  AST_DROP_ONLY_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fire_i && blocked) |=> $stable(drop_q)); // R8
  AST_FIRE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && ready_i) |=> (valid_q && row_q == $past(row_i))); // R9
endmodule

// File: rtl/nbr_refresh_top.sv
module nbr_refresh_top
  import nbr_refresh_pkg::*;
#(
  parameter int unsigned ROWS   = 65536,
  parameter int unsigned ROW_W  = $clog2(ROWS),
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_valid_i,
  input  logic [ROW_W-1:0]  act_row_i,
  input  logic [15:0]       prob_i,
  input  logic              seed_load_i,
  input  logic [15:0]       seed_i,
  output logic              ref_valid_o,
  output logic [ROW_W-1:0]  ref_row_o,
  input  logic              ref_ready_i,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic [LFSR_W-1:0] rnd;
  logic              rnd_fb;
  logic              fire;
  logic [ROW_W-1:0]  victim;
  nbr_dir_e          dir;

  nbr_lfsr u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (act_valid_i),
    .load_i  (seed_load_i),
    .seed_i  (seed_i),
    .state_o (rnd),
    .fb_o    (rnd_fb)
  );

  // compare against the pre-step value, strictly less
  assign fire = act_valid_i && (rnd < prob_i);
  assign dir  = nbr_dir_e'(rnd_fb);

  nbr_select #(.ROWS(ROWS), .ROW_W(ROW_W)) u_sel (
    .row_i (act_row_i),
    .dir_i (dir),
    .nbr_o (victim)
  );

  nbr_req_slot #(.ROW_W(ROW_W), .DROP_W(DROP_W)) u_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .row_i      (victim),
    .ready_i    (ref_ready_i),
    .valid_o    (ref_valid_o),
    .row_o      (ref_row_o),
    .drop_cnt_o (drop_cnt_o)
  );

  AST_NBR_ADJACENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_valid_i |-> ((victim == act_row_i + ROW_W'(1)) || (victim + ROW_W'(1) == act_row_i))); // R5
  AST_NBR_IN_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_valid_o |-> (32'(ref_row_o) < ROWS)); // R6
  AST_ZERO_PROB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_valid_i && prob_i == '0) |-> !fire); // R2
  AST_NO_ACT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_valid_i && !ref_valid_o) |=> !ref_valid_o); // R10
endmodule

// File: tb/nbr_refresh_top_test.sv
module nbr_refresh_top_test;
  localparam int ROWS   = 16;
  localparam int ROW_W  = 4;
  localparam int DROP_W = 4;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             act_valid = 0;
  logic [ROW_W-1:0] act_row = '0;
  logic [15:0]      prob = '0;
  logic             seed_load = 0;
  logic [15:0]      seed = '0;
  logic             ready = 0;
  logic             ref_valid;
  logic [ROW_W-1:0] ref_row;
  logic [DROP_W-1:0] drop_cnt;

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R1";

  // reference model
  int m_lfsr = 'hACE1;
  bit m_valid = 0;
  int m_row = 0;
  int m_drop = 0;

  always #4 clk = ~clk; // 125 MHz

  nbr_refresh_top #(.ROWS(ROWS), .DROP_W(DROP_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .act_valid_i(act_valid), .act_row_i(act_row),
    .prob_i(prob), .seed_load_i(seed_load), .seed_i(seed),
    .ref_valid_o(ref_valid), .ref_row_o(ref_row), .ref_ready_i(ready),
    .drop_cnt_o(drop_cnt));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lfsr = 'hACE1; m_valid = 0; m_row = 0; m_drop = 0;
    end else begin
      int fb, nb;
      bit fire, blocked;
      fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
      fire = act_valid && (m_lfsr < int'(prob));
      if (act_row == 0) nb = 1;
      else if (int'(act_row) == ROWS-1) nb = ROWS-2;
      else nb = fb ? int'(act_row) + 1 : int'(act_row) - 1;
      blocked = m_valid && !ready;
      if (fire && blocked) begin
        if (m_drop < (1 << DROP_W) - 1) m_drop++;
      end else if (fire) begin
        m_valid = 1; m_row = nb;
      end else if (ready) m_valid = 0;
      if (seed_load) m_lfsr = (seed == 0) ? 'hACE1 : int'(seed);
      else if (act_valid) m_lfsr = ((m_lfsr << 1) | fb) & 'hFFFF;
    end
  end

  task automatic check(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic compare();
    check(req, "ref_valid", int'(ref_valid), int'(m_valid));
    if (m_valid) check(req, "ref_row", int'(ref_row), m_row);
    check(req, "drop_cnt", int'(drop_cnt), m_drop);
  endtask

  // one cycle: compare at negedge, then drive next inputs
  task automatic step(bit a, int row, bit rdy);
    @(negedge clk);
    compare();
    act_valid = a; act_row = ROW_W'(row); ready = rdy;
    seed_load = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "ref_valid", int'(ref_valid), 0);
    check("R1", "drop_cnt", int'(drop_cnt), 0);
    rst_n = 1;
    // R4 zero seed falls back, R10 latency seen via model
    req = "R4";
    @(negedge clk); seed = 0; seed_load = 1; prob = 16'hFFFF; ready = 1;
    for (int i = 0; i < 20; i++) step(1, 5 + (i % 3), 1);
    // R2 probability zero never fires
    req = "R2";
    prob = 16'h0000;
    for (int i = 0; i < 200; i++) step(1, int'($urandom_range(0, ROWS-1)), 1);
    // R5 typical probability, random rows and ready
    req = "R5";
    prob = 16'd13107;
    for (int i = 0; i < 400; i++)
      step(bit'($urandom_range(0, 1)), int'($urandom_range(0, ROWS-1)), 1);
    // R6 bank edge rows
    req = "R6";
    prob = 16'hFFFF;
    for (int i = 0; i < 60; i++) step(1, (i % 2) ? ROWS-1 : 0, 1);
    // R3 idle cycles hold the LFSR, then resume
    req = "R3";
    prob = 16'h8000;
    for (int i = 0; i < 30; i++) step(i % 4 == 0, 7, 1);
    // R7 stall keeps request; R8 drops saturate
    req = "R7";
    prob = 16'hFFFF;
    step(1, 9, 1);
    for (int i = 0; i < 8; i++) step(0, 3, 0);
    req = "R8";
    for (int i = 0; i < 40; i++) step(1, int'($urandom_range(1, ROWS-2)), 0);
    // R9 replace while ready
    req = "R9";
    for (int i = 0; i < 30; i++) step(1, int'($urandom_range(0, ROWS-1)), 1);
    for (int i = 0; i < 5; i++) step(0, 0, 1);
    // R4 non-zero seed coinciding with an activate
    req = "R4";
    prob = 16'h4000;
    @(negedge clk); compare();
    seed = 16'h1234; seed_load = 1; act_valid = 1; act_row = 4'd6; ready = 1;
    for (int i = 0; i < 100; i++)
      step(1, int'($urandom_range(0, ROWS-1)), bit'($urandom_range(0, 1)));
    // R2 rare probability about 0.001
    req = "R2";
    prob = 16'd66;
    for (int i = 0; i < 3000; i++)
      step(1, int'($urandom_range(0, ROWS-1)), bit'($urandom_range(0, 3) != 0));
    req = "R10";
    for (int i = 0; i < 5; i++) step(0, 0, 1);
    finish_run();
  end
endmodule